// File: doc/BRIEF.md
# Byte-Lane Register File with Operand Legality Checking

This block holds the working registers of a small 16-bit processor datapath. It has twelve registers in three groups. The four data registers can be used as whole words or as two separate byte halves. The four pointer/index registers and the four segment registers can only be used as whole words. There are two combinational read ports and one synchronous write port. Every port carries a register selector, a byte-or-word size flag and, for byte accesses, a half select.

A write either loads an immediate or copies a register. For a copy, the source is whatever read port A currently selects. Before any write is committed, the block checks that the request is legal. It rejects the following:
- a source and destination of different sizes;
- a byte access to a word-only register;
- an immediate too wide for its destination;
- an immediate aimed at a segment register;
- a selector outside the map.

A rejected request raises an error flag in the same cycle and leaves every register untouched. Instruction decoding and memory access belong to other blocks.

Top module: `split_regfile`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears all twelve registers to zero.
- R2: Selector map: 0–3 are the byte-capable data registers, 4–7 are word-only pointer/index registers, and 8–11 are segment registers. A legal word write is returned in full by a word read of the same selector.
- R3: A byte read (byte flag 1) returns bits 7:0 when the half select is 0 and bits 15:8 when it is 1. The byte appears in the low byte of the read data, and the upper byte reads as zero.
- R4: A legal byte write stores the byte in the half chosen by the half select and leaves the other half bit-for-bit unchanged.
- R5: A byte access to a selector from 4 to 11 is illegal. A byte read of such a selector raises the read error and returns zero. A byte write to it raises the write error and changes nothing.
- R6: A register copy is legal only when the source size (port A byte flag) equals the destination size (write byte flag). A mismatch raises the write error and leaves the destination unchanged.
- R7: An immediate write to a segment register (8–11) raises the write error and changes nothing. A copy from a legal non-segment source into a segment register is performed.
- R8: A legal immediate shorter than the destination is zero-extended: every bit of a word destination above the immediate's value is cleared.
- R9: A 24-bit immediate with any bit above bit 7 set is illegal for a byte destination. One with any bit above bit 15 set is illegal for a word destination. Either case raises the write error and writes nothing.
- R10: Reads are combinational. A read of a register being written in the same cycle returns the old value, and the new value appears after the rising edge.
- R11: Selectors 12–15 are illegal on every port: reads raise the read error and return zero, and writes raise the write error and write nothing.
- R12: The write error is low whenever the write enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rdSelA | input | 4 | Read port A selector, also the copy source |
| rdByteA | input | 1 | Port A size: 1 byte, 0 word |
| rdHighA | input | 1 | Port A half: 1 upper byte, 0 lower byte |
| rdDataA | output | 16 | Port A data, bytes zero-extended |
| rdErrA | output | 1 | Port A access illegal |
| rdSelB | input | 4 | Read port B selector |
| rdByteB | input | 1 | Port B size: 1 byte, 0 word |
| rdHighB | input | 1 | Port B half: 1 upper byte, 0 lower byte |
| rdDataB | output | 16 | Port B data, bytes zero-extended |
| rdErrB | output | 1 | Port B access illegal |
| wrEn | input | 1 | Write request |
| wrSel | input | 4 | Destination selector |
| wrByte | input | 1 | Destination size: 1 byte, 0 word |
| wrHigh | input | 1 | Destination half for byte writes |
| wrUseImm | input | 1 | 1 loads wrImm, 0 copies port A |
| wrImm | input | 24 | Immediate value |
| wrErr | output | 1 | Write request illegal, not performed |

## Verification
A wrong internal state stays hidden until a read port selects the corrupted register. The bench therefore re-reads the destination through port B one cycle after every write. It reads whole words, so the untouched half of a byte write is observed as well. A wrong legality decision shows at once on wrErr, in the same cycle as the request. Its effect on storage is visible one edge later. Copies are checked in two places: the source value is checked on port A, and the destination is checked on port B.

// File: rtl/prf_pkg.sv
package prf_pkg;
  localparam int DATA_W   = 16;
  localparam int HALF_W   = DATA_W / 2;
  localparam int IMM_W    = DATA_W + HALF_W;
  localparam int NUM_DATA = 4;
  localparam int NUM_PTR  = 4;
  localparam int NUM_SEG  = 4;
  localparam int NREG     = NUM_DATA + NUM_PTR + NUM_SEG;
  localparam int SEL_W    = $clog2(NREG);
  localparam int NRD      = 2;

  typedef enum logic [1:0] {
    CLS_DATA,
    CLS_WORD,
    CLS_SEG,
    CLS_NONE
  } regClass_t;

  typedef struct packed {
    logic [NREG-1:0]   loEn;
    logic [NREG-1:0]   hiEn;
    logic [DATA_W-1:0] wrData;
  } wrStrobe_t;

  typedef struct packed {
    logic [NRD-1:0] ok;
  } rdGate_t;

  function automatic regClass_t classOf(input logic [SEL_W-1:0] sel);
    if (int'(sel) < NUM_DATA)                return CLS_DATA;
    else if (int'(sel) < NUM_DATA + NUM_PTR) return CLS_WORD;
    else if (int'(sel) < NREG)               return CLS_SEG;
    else                                     return CLS_NONE;
  endfunction
endpackage

// File: rtl/prf_ctrl.sv
module prf_ctrl
  import prf_pkg::*;
(
  input  logic [NRD-1:0][SEL_W-1:0] rdSel,
  input  logic [NRD-1:0]            rdByte,
  input  logic [DATA_W-1:0]         srcData,
  input  logic                      wrEn,
  input  logic [SEL_W-1:0]          wrSel,
  input  logic                      wrByte,
  input  logic                      wrHigh,
  input  logic                      wrUseImm,
  input  logic [IMM_W-1:0]          wrImm,
  output rdGate_t                   rdG,
  output wrStrobe_t                 wrS,
  output logic                      wrErr
);
  logic [NRD-1:0]    rdOk;
  regClass_t         dstCls;
  logic              dstOk;
  logic              immFits;
  logic              immOk;
  logic              movOk;
  logic              legal;
  logic              commit;
  logic [DATA_W-1:0] payload;

  always_comb begin
    for (int p = 0; p < NRD; p++) begin
      rdOk[p] = (classOf(rdSel[p]) != CLS_NONE) &&
                (!rdByte[p] || classOf(rdSel[p]) == CLS_DATA);
    end
    rdG.ok = rdOk;
  end

  always_comb begin
    dstCls  = classOf(wrSel);
    dstOk   = (dstCls != CLS_NONE) && (!wrByte || dstCls == CLS_DATA);
    immFits = wrByte ? ~|wrImm[IMM_W-1:HALF_W] : ~|wrImm[IMM_W-1:DATA_W];
    immOk   = immFits && (dstCls != CLS_SEG);
    movOk   = rdOk[0] && (rdByte[0] == wrByte);
    legal   = dstOk && (wrUseImm ? immOk : movOk);
    wrErr   = wrEn && !legal;
    commit  = wrEn && legal;
  end

  always_comb begin
    payload    = wrUseImm ? wrImm[DATA_W-1:0] : srcData;
    wrS.wrData = wrByte ? {2{payload[HALF_W-1:0]}} : payload;
    wrS.loEn   = '0;
    wrS.hiEn   = '0;
    for (int r = 0; r < NREG; r++) begin
      if (commit && wrSel == SEL_W'(r)) begin
        wrS.loEn[r] = !wrByte || !wrHigh;
        wrS.hiEn[r] = !wrByte || wrHigh;
      end
    end
  end
endmodule

// File: rtl/prf_datapath.sv
module prf_datapath
  import prf_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  wrStrobe_t                  wrS,
  input  rdGate_t                    rdG,
  input  logic [NRD-1:0][SEL_W-1:0]  rdSel,
  input  logic [NRD-1:0]             rdByte,
  input  logic [NRD-1:0]             rdHigh,
  output logic [NRD-1:0][DATA_W-1:0] rdData
);
  logic [NREG-1:0][DATA_W-1:0] regs;

  always_ff @(posedge clk) begin
    if (rst) begin
      regs <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (wrS.loEn[r]) regs[r][HALF_W-1:0]      <= wrS.wrData[HALF_W-1:0];
        if (wrS.hiEn[r]) regs[r][DATA_W-1:HALF_W] <= wrS.wrData[DATA_W-1:HALF_W];
      end
    end
  end

  function automatic logic [DATA_W-1:0] pickWord(input logic [SEL_W-1:0] sel,
                                                 input logic [NREG-1:0][DATA_W-1:0] bank);
    logic [DATA_W-1:0] word;
    word = '0;
    for (int r = 0; r < NREG; r++) begin
      if (sel == SEL_W'(r)) word = bank[r];
    end
    return word;
  endfunction

  for (genvar p = 0; p < NRD; p++) begin : g_rdPort
    logic [DATA_W-1:0] word;
    assign word = pickWord(rdSel[p], regs);
    assign rdData[p] = !rdG.ok[p] ? '0 :
                       !rdByte[p] ? word :
                       rdHigh[p]  ? {{HALF_W{1'b0}}, word[DATA_W-1:HALF_W]} :
                                    {{HALF_W{1'b0}}, word[HALF_W-1:0]};
  end
endmodule

// File: rtl/split_regfile.sv
module split_regfile
  import prf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  rdSelA,
  input  logic              rdByteA,
  input  logic              rdHighA,
  output logic [DATA_W-1:0] rdDataA,
  output logic              rdErrA,
  input  logic [SEL_W-1:0]  rdSelB,
  input  logic              rdByteB,
  input  logic              rdHighB,
  output logic [DATA_W-1:0] rdDataB,
  output logic              rdErrB,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic              wrByte,
  input  logic              wrHigh,
  input  logic              wrUseImm,
  input  logic [IMM_W-1:0]  wrImm,
  output logic              wrErr
);
  logic [NRD-1:0][SEL_W-1:0]  rdSel;
  logic [NRD-1:0]             rdByte;
  logic [NRD-1:0]             rdHigh;
  logic [NRD-1:0][DATA_W-1:0] rdData;
  rdGate_t                    rdG;
  wrStrobe_t                  wrS;

  assign rdSel   = {rdSelB, rdSelA};
  assign rdByte  = {rdByteB, rdByteA};
  assign rdHigh  = {rdHighB, rdHighA};
  assign rdDataA = rdData[0];
  assign rdDataB = rdData[1];
  assign rdErrA  = !rdG.ok[0];
  assign rdErrB  = !rdG.ok[1];

  prf_ctrl u_ctrl (
    .rdSel(rdSel), .rdByte(rdByte), .srcData(rdData[0]),
    .wrEn(wrEn), .wrSel(wrSel), .wrByte(wrByte), .wrHigh(wrHigh),
    .wrUseImm(wrUseImm), .wrImm(wrImm),
    .rdG(rdG), .wrS(wrS), .wrErr(wrErr)
  );

  prf_datapath u_dp (
    .clk(clk), .rst(rst), .wrS(wrS), .rdG(rdG),
    .rdSel(rdSel), .rdByte(rdByte), .rdHigh(rdHigh), .rdData(rdData)
  );
endmodule

// File: rtl/prf_checker.sv
module prf_checker
  import prf_pkg::*;
(
  input logic                        clk,
  input logic                        rst,
  input logic                        wrEn,
  input logic [SEL_W-1:0]            wrSel,
  input logic                        wrByte,
  input logic                        wrHigh,
  input logic                        wrUseImm,
  input logic [IMM_W-1:0]            wrImm,
  input logic                        wrErr,
  input logic [DATA_W-1:0]           rdDataA,
  input logic                        rdErrA,
  input logic [DATA_W-1:0]           rdDataB,
  input logic                        rdErrB,
  input logic [NREG-1:0][DATA_W-1:0] regState
);
  logic [DATA_W-1:0] movPayload;
  assign movPayload = wrUseImm ? wrImm[DATA_W-1:0] : rdDataA;

  // R1
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> regState == '0);

  // R6, R5, R9, R11: rejected writes leave storage alone
  a_r6_err_no_write: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrErr) |=> $stable(regState));

  // R4
  a_r4_lo_keeps_hi: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !wrErr && wrByte && !wrHigh) |=>
      regState[$past(wrSel)][DATA_W-1:HALF_W] == $past(regState[wrSel][DATA_W-1:HALF_W]));

  a_r4_hi_keeps_lo: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !wrErr && wrByte && wrHigh) |=>
      regState[$past(wrSel)][HALF_W-1:0] == $past(regState[wrSel][HALF_W-1:0]));

  // R2, R10
  a_r2_word_lands: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !wrErr && !wrByte) |=> regState[$past(wrSel)] == $past(movPayload));

  // R5, R11
  a_r5_rd_err_zero: assert property (@(posedge clk) disable iff (rst)
    (rdErrA |-> rdDataA == '0) and (rdErrB |-> rdDataB == '0));

  // R7
  a_r7_seg_imm_err: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrUseImm && int'(wrSel) >= NUM_DATA + NUM_PTR && int'(wrSel) < NREG) |-> wrErr);

  // R9
  a_r9_wide_imm_err: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrUseImm && wrByte && wrImm[IMM_W-1:HALF_W] != '0) |-> wrErr);

  // R11
  a_r11_bad_sel_err: assert property (@(posedge clk) disable iff (rst)
    (wrEn && int'(wrSel) >= NREG) |-> wrErr);

  // R12
  a_r12_idle_no_err: assert property (@(posedge clk) disable iff (rst)
    !wrEn |-> !wrErr);
endmodule

bind split_regfile prf_checker i_prf_checker (
  .clk(clk), .rst(rst), .wrEn(wrEn), .wrSel(wrSel), .wrByte(wrByte),
  .wrHigh(wrHigh), .wrUseImm(wrUseImm), .wrImm(wrImm), .wrErr(wrErr),
  .rdDataA(rdDataA), .rdErrA(rdErrA), .rdDataB(rdDataB), .rdErrB(rdErrB),
  .regState(u_dp.regs)
);

// File: tb/test_split_regfile.sv
`timescale 1ns/1ps
module test_split_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  rdSelA = '0, rdSelB = '0, wrSel = '0;
  logic        rdByteA = 0, rdHighA = 0, rdByteB = 0, rdHighB = 0;
  logic [15:0] rdDataA, rdDataB;
  logic        rdErrA, rdErrB, wrErr;
  logic        wrEn = 0, wrByte = 0, wrHigh = 0, wrUseImm = 0;
  logic [23:0] wrImm = '0;

  int          nChecks = 0, nFails = 0;
  bit          finished = 0;
  logic [15:0] model [12];

  always #2 clk = ~clk;

  split_regfile i_split_regfile (
    .clk(clk), .rst(rst),
    .rdSelA(rdSelA), .rdByteA(rdByteA), .rdHighA(rdHighA), .rdDataA(rdDataA), .rdErrA(rdErrA),
    .rdSelB(rdSelB), .rdByteB(rdByteB), .rdHighB(rdHighB), .rdDataB(rdDataB), .rdErrB(rdErrB),
    .wrEn(wrEn), .wrSel(wrSel), .wrByte(wrByte), .wrHigh(wrHigh),
    .wrUseImm(wrUseImm), .wrImm(wrImm), .wrErr(wrErr)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] expRd(input int sel, input bit isByte, input bit hi, output bit err);
    err = 0;
    if (sel >= 12 || (isByte && sel >= 4)) begin
      err = 1;
      return 16'h0;
    end
    if (!isByte) return model[sel];
    return hi ? {8'h00, model[sel][15:8]} : {8'h00, model[sel][7:0]};
  endfunction

  task automatic checkRd(input int sel, input bit b, input bit h, input string tag);
    logic [15:0] e;
    bit          ee;
    @(negedge clk);
    wrEn = 0;
    rdSelB = 4'(sel); rdByteB = b; rdHighB = h;
    #1;
    e = expRd(sel, b, h, ee);
    check(rdDataB == e, tag, 32'(rdDataB), 32'(e));
    check(rdErrB == ee, {tag, " err"}, 32'(rdErrB), 32'(ee));
  endtask

  task automatic doWrite(input int dst, input bit isByte, input bit hi, input bit useImm,
                         input logic [23:0] imm, input int src, input bit srcByte,
                         input bit srcHigh, input string tag);
    logic [15:0] srcVal, val;
    bit          srcErr, legal, seg;
    @(negedge clk);
    rdSelA = 4'(src); rdByteA = srcByte; rdHighA = srcHigh;
    wrSel = 4'(dst); wrByte = isByte; wrHigh = hi; wrUseImm = useImm; wrImm = imm; wrEn = 1;
    srcVal = expRd(src, srcByte, srcHigh, srcErr);
    seg    = (dst >= 8 && dst < 12);
    legal  = dst < 12 && !(isByte && dst >= 4);
    if (useImm) legal = legal && !seg && (isByte ? imm < 24'h100 : imm < 24'h10000);
    else        legal = legal && !srcErr && (srcByte == isByte);
    #1;
    check(wrErr == !legal, {tag, " wrErr"}, 32'(wrErr), 32'(!legal));
    if (!useImm) check(rdDataA == srcVal, {tag, " R3 srcA"}, 32'(rdDataA), 32'(srcVal));
    @(posedge clk);
    #1;
    wrEn = 0;
    if (legal) begin
      val = useImm ? imm[15:0] : srcVal;
      if (!isByte)  model[dst] = val;
      else if (hi)  model[dst][15:8] = val[7:0];
      else          model[dst][7:0] = val[7:0];
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    for (int i = 0; i < 12; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    for (int i = 0; i < 12; i++) doWrite(i, 0, 0, 1, 24'h00A5 + 24'(i), 0, 0, 0, "setup");
    for (int i = 0; i < 12; i++) doWrite(i, 0, 0, 0, 0, 1, 0, 0, "R7 copy");
    @(negedge clk) rst = 1;
    @(posedge clk);
    #1 rst = 0;
    for (int i = 0; i < 12; i++) model[i] = '0;
    for (int i = 0; i < 12; i++) checkRd(i, 0, 0, "R1 reset");

    doWrite(0, 0, 0, 1, 24'h1234, 0, 0, 0, "R2 word imm");
    checkRd(0, 0, 0, "R2 word read");
    checkRd(0, 1, 0, "R3 low byte");
    checkRd(0, 1, 1, "R3 high byte");

    doWrite(1, 0, 0, 1, 24'h5566, 0, 0, 0, "R2");
    doWrite(1, 1, 1, 1, 24'h00AB, 0, 0, 0, "R4 hi");
    checkRd(1, 0, 0, "R4 hi write keeps lo");
    doWrite(1, 1, 0, 1, 24'h00CD, 0, 0, 0, "R4 lo");
    checkRd(1, 0, 0, "R4 lo write keeps hi");

    doWrite(5, 0, 0, 1, 24'h9999, 0, 0, 0, "R2 ptr");
    checkRd(5, 1, 0, "R5 byte read word-only");
    doWrite(6, 1, 0, 1, 24'h0011, 0, 0, 0, "R5 byte write word-only");
    checkRd(6, 0, 0, "R5 unchanged");

    doWrite(2, 0, 0, 0, 0, 0, 1, 0, "R6 byte to word");
    checkRd(2, 0, 0, "R6 unchanged");
    doWrite(3, 1, 1, 0, 0, 5, 0, 0, "R6 word to byte");
    checkRd(3, 0, 0, "R6 unchanged");
    doWrite(3, 1, 1, 0, 0, 0, 1, 0, "R6 byte to byte");
    checkRd(3, 0, 0, "R6 byte copy");

    doWrite(9, 0, 0, 1, 24'h2345, 0, 0, 0, "R7 imm to seg");
    checkRd(9, 0, 0, "R7 unchanged");
    doWrite(9, 0, 0, 0, 0, 0, 0, 0, "R7 copy to seg");
    checkRd(9, 0, 0, "R7 seg loaded");

    doWrite(4, 0, 0, 1, 24'hFFFF, 0, 0, 0, "R8 fill");
    doWrite(4, 0, 0, 1, 24'h0005, 0, 0, 0, "R8 small imm");
    checkRd(4, 0, 0, "R8 zero extend");

    doWrite(2, 1, 0, 1, 24'h01F2, 0, 0, 0, "R9 wide byte imm");
    checkRd(2, 0, 0, "R9 unchanged");
    doWrite(7, 0, 0, 1, 24'h2FE456, 0, 0, 0, "R9 wide word imm");
    checkRd(7, 0, 0, "R9 unchanged");

    // R10: same-cycle read sees the old value
    @(negedge clk);
    rdSelB = 4'd3; rdByteB = 0; rdHighB = 0;
    wrSel = 4'd3; wrByte = 0; wrUseImm = 1; wrImm = 24'hBEEF; wrEn = 1;
    #1 check(rdDataB == model[3], "R10 old value", 32'(rdDataB), 32'(model[3]));
    @(posedge clk);
    #1 wrEn = 0;
    model[3] = 16'hBEEF;
    check(rdDataB == 16'hBEEF, "R10 new value", 32'(rdDataB), 32'hBEEF);

    doWrite(13, 0, 0, 1, 24'h0001, 0, 0, 0, "R11 bad write sel");
    checkRd(14, 0, 0, "R11 bad read sel");

    @(negedge clk) wrEn = 0;
    #1 check(wrErr == 0, "R12 idle", 32'(wrErr), 0);

    for (int n = 0; n < 400; n++) begin
      int          dst, src, k;
      bit          b, h, imm, sb, sh;
      logic [23:0] v;
      dst = int'($urandom % 16); src = int'($urandom % 16);
      b = 1'($urandom); h = 1'($urandom); imm = 1'($urandom);
      sb = 1'($urandom); sh = 1'($urandom);
      k = int'($urandom % 4);
      v = (k == 0) ? 24'($urandom % 256) : (k == 3) ? 24'($urandom) : 24'($urandom % 65536);
      if (dst < 12 && $urandom % 3 != 0) begin
        b = b && dst < 4;
        sb = b;
        if (src >= 12 || (sb && src >= 4)) src = int'($urandom % 4);
      end
      doWrite(dst, b, h, imm, v, src, sb, sh, "R2 random");
      checkRd(dst % 12, 0, 0, "R4 random readback");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule